// File: doc/BRIEF.md
# General Purpose I/O Bank with Atomic Set/Clear

This block is a bank of general purpose pins behind a small register bus. Software picks the direction of every pin at run time, drives the pins that are outputs from an output latch, and reads back both the latch and the live pin levels as two separate values. Pin levels are brought into the clock domain through a two-stage synchronizer before they can be read.

The latch can be loaded whole, or changed one bit group at a time. A set register turns on the bits written as 1 and a clear register turns them off. In both cases the bits written as 0 keep their value, so no read-modify-write sequence is needed. A combined register carries a set mask and a clear mask in a single write. When both masks name the same bit, the clear mask wins.

The bus is a plain single-cycle strobe interface with no back-pressure. A write takes effect at the clock edge that samples it. A read loads `bus_rdata` at the edge that samples the read strobe, and `bus_rdata` keeps that value until the next read. No data stream passes through the block, so it has no valid/ready interface.

Top module: `gpio_bank`

## Requirements
- R1: A write to address 0 (direction) loads `pin_oe` from `bus_wdata[WIDTH-1:0]` at that edge, where 1 means output. `pin_oe` changes at no other time, and reading address 0 returns it.
- R2: A write to address 1 (latch) loads the output latch from `bus_wdata[WIDTH-1:0]`. The latch appears on `pin_out` after that edge.
- R3: A write to address 2 (set) drives high every latch bit written as 1 and leaves every other latch bit unchanged.
- R4: A write to address 3 (clear) drives low every latch bit written as 1 and leaves every other latch bit unchanged.
- R5: A write to address 5 takes a set mask from `bus_wdata[WIDTH-1:0]` and a clear mask from `bus_wdata[16+WIDTH-1:16]`. A bit named in both masks ends low.
- R6: The latch keeps its value while a pin is an input. `pin_out` keeps showing the latch, and reading address 1 returns the latch whatever the direction.
- R7: Reading address 4 returns the pin levels after two synchronizer flops. A level applied before edge k is returned by a read sampled at edge k+2, and not by a read sampled earlier.
- R8: Reads of addresses 2, 3, 5, 6 and 7 return zero. Writes to addresses 4, 6 and 7 change neither the direction nor the latch.
- R9: After reset every pin is an input, the latch is zero, the synchronizer holds zero and `bus_rdata` is zero.
- R10: `bus_rdata` changes only at an edge where `bus_rd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, zero above WIDTH |
| pin_in | input | WIDTH | Live pin levels, asynchronous |
| pin_out | output | WIDTH | Output latch value driven to the pads |
| pin_oe | output | WIDTH | Output enable per pin, 1 = drive |

## Verification
Two cases are hard to reach from the ports. The first is a combined write whose set and clear masks overlap on some bits while other bits take only one of the two masks. The bench starts from a latch value with both ones and zeros and writes overlapping masks, so that bits which end high, bits which end low and bits which stay unchanged are all visible in one step. The second is the exact synchronizer latency. The bench changes the pin levels in the same cycle as it starts a run of back-to-back pin reads, and checks each read in turn. A behavioural reference model, which keeps the pin history as an array, is compared on every clock while a random run of reads and writes goes on.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 3;
  localparam int CLR_LSB = 16;

  typedef enum logic [ADDR_W-1:0] {
    A_DIR    = 3'd0,
    A_LAT    = 3'd1,
    A_SET    = 3'd2,
    A_CLR    = 3'd3,
    A_PIN    = 3'd4,
    A_SETCLR = 3'd5
  } gpio_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else if (s == 0) chain[s] <= d_async;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  lat_q
);
  logic [WIDTH-1:0] data_lo, data_hi;
  logic [WIDTH-1:0] set_mask, clr_mask, lat_d;
  logic             load_lat;
  logic             unused_wdata;

  assign data_lo      = wdata[WIDTH-1:0];
  assign data_hi      = wdata[CLR_LSB +: WIDTH];
  assign unused_wdata = ^wdata;

  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    load_lat = 1'b0;
    if (wr) begin
      unique case (addr)
        A_LAT:    load_lat = 1'b1;
        A_SET:    set_mask = data_lo;
        A_CLR:    clr_mask = data_lo;
        A_SETCLR: begin
          set_mask = data_lo;
          clr_mask = data_hi;
        end
        default: ;
      endcase
    end
    // clear is applied last so it wins on overlapping bits
    lat_d = load_lat ? data_lo : ((lat_q | set_mask) & ~clr_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      lat_q <= '0;
    end else begin
      if (wr && addr == A_DIR) dir_q <= data_lo;
      lat_q <= lat_d;
    end
  end
endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux
  import gpio_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  dir_q,
  input  logic [WIDTH-1:0]  lat_q,
  input  logic [WIDTH-1:0]  pin_q,
  output logic [DATA_W-1:0] rdata
);
  logic [WIDTH-1:0] sel;

  always_comb begin
    unique case (addr)
      A_DIR:   sel = dir_q;
      A_LAT:   sel = lat_q;
      A_PIN:   sel = pin_q;
      default: sel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (rd) rdata <= DATA_W'(sel);
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe
);
  logic [WIDTH-1:0] dir_q, lat_q, pin_q;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pin_in), .q_sync(pin_q)
  );

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .dir_q(dir_q), .lat_q(lat_q)
  );

  gpio_rdmux #(.WIDTH(WIDTH)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd(bus_rd), .addr(bus_addr),
    .dir_q(dir_q), .lat_q(lat_q), .pin_q(pin_q), .rdata(bus_rdata)
  );

  assign pin_out = lat_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [WIDTH-1:0]  pin_out,
  input logic [WIDTH-1:0]  pin_oe
);
  logic [WIDTH-1:0] w_lo, w_hi;
  assign w_lo = bus_wdata[WIDTH-1:0];
  assign w_hi = bus_wdata[CLR_LSB +: WIDTH];

  p_dir_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DIR) |=> pin_oe == $past(w_lo));

  p_dir_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == A_DIR) |=> $stable(pin_oe));

  p_set_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_SET) |=> (pin_out & $past(w_lo)) == $past(w_lo));

  p_set_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_SET) |=> ((pin_out ^ $past(pin_out)) & ~$past(w_lo)) == '0);

  p_clr_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CLR) |=> (pin_out & $past(w_lo)) == '0);

  p_clr_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CLR) |=> ((pin_out ^ $past(pin_out)) & ~$past(w_lo)) == '0);

  p_clr_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_SETCLR) |=> (pin_out & $past(w_hi)) == '0);

  p_lat_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr >= 3'd6) |=> $stable(pin_out));

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind gpio_bank gpio_bank_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/gpio_bank_tb_top.sv
module gpio_bank_tb_top;
  localparam int W = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [W-1:0]  pin_in = '0, pin_out, pin_oe;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_bank #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // behavioural reference model
  logic [W-1:0] m_dir, m_lat;
  logic [W-1:0] m_hist [2];
  logic [31:0]  m_rdata;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = '0; m_lat = '0; m_hist[0] = '0; m_hist[1] = '0; m_rdata = '0;
    end else begin
      if (bus_rd) begin
        case (bus_addr)
          3'd0: m_rdata = {24'd0, m_dir};
          3'd1: m_rdata = {24'd0, m_lat};
          3'd4: m_rdata = {24'd0, m_hist[1]};
          default: m_rdata = 32'd0;
        endcase
      end
      if (bus_wr) begin
        case (bus_addr)
          3'd0: m_dir = bus_wdata[W-1:0];
          3'd1: m_lat = bus_wdata[W-1:0];
          3'd2: m_lat = m_lat | bus_wdata[W-1:0];
          3'd3: m_lat = m_lat & ~bus_wdata[W-1:0];
          3'd5: begin
            m_lat = m_lat | bus_wdata[W-1:0];
            m_lat = m_lat & ~bus_wdata[16 +: W];
          end
          default: ;
        endcase
      end
      m_hist[1] = m_hist[0];
      m_hist[0] = pin_in;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R1 pin_oe", {24'd0, pin_oe}, {24'd0, m_dir});
      check("R2 pin_out", {24'd0, pin_out}, {24'd0, m_lat});
      check("R10 bus_rdata", bus_rdata, m_rdata);
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    cyc();
  endtask

  task automatic rd(input logic [2:0] a);
    bus_rd = 1'b1; bus_addr = a;
    cyc();
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset oe", {24'd0, pin_oe}, 32'd0);
    check("R9 reset out", {24'd0, pin_out}, 32'd0);
    check("R9 reset rdata", bus_rdata, 32'd0);
    rst_n = 1'b1;
    cyc();

    wr(3'd0, 32'hF0);
    check("R1 dir load", {24'd0, pin_oe}, 32'hF0);
    rd(3'd0);
    check("R1 dir read", bus_rdata, 32'hF0);

    wr(3'd1, 32'h5A);
    check("R2 latch load", {24'd0, pin_out}, 32'h5A);
    wr(3'd2, 32'h81);
    check("R3 set", {24'd0, pin_out}, 32'hDB);
    wr(3'd3, 32'h0A);
    check("R4 clear", {24'd0, pin_out}, 32'hD1);
    wr(3'd5, 32'h0003_000F);
    check("R5 set+clear overlap", {24'd0, pin_out}, 32'hDC);

    wr(3'd0, 32'h00);
    check("R6 oe off", {24'd0, pin_oe}, 32'h00);
    check("R6 latch kept", {24'd0, pin_out}, 32'hDC);
    rd(3'd1);
    check("R6 latch read", bus_rdata, 32'hDC);

    // R7: pins change together with the first of three back-to-back reads
    pin_in = 8'hA5;
    rd(3'd4);
    check("R7 edge k", bus_rdata, 32'h00);
    rd(3'd4);
    check("R7 edge k+1", bus_rdata, 32'h00);
    rd(3'd4);
    check("R7 edge k+2", bus_rdata, 32'hA5);

    // R8
    wr(3'd4, 32'hFF);
    wr(3'd6, 32'hFF);
    wr(3'd7, 32'hFF);
    rd(3'd1);
    check("R8 latch untouched", bus_rdata, 32'hDC);
    rd(3'd0);
    check("R8 dir untouched", bus_rdata, 32'h00);
    rd(3'd2);
    check("R8 set reads zero", bus_rdata, 32'h0);
    rd(3'd1);
    rd(3'd7);
    check("R8 unmapped reads zero", bus_rdata, 32'h0);

    // R10
    rd(3'd1);
    wr(3'd2, 32'h01);
    cyc();
    check("R10 rdata held", bus_rdata, 32'hDC);

    for (int i = 0; i < 400; i++) begin
      bus_wr    = $urandom_range(0, 1);
      bus_rd    = $urandom_range(0, 1);
      bus_addr  = 3'($urandom_range(0, 7));
      bus_wdata = $urandom;
      pin_in    = 8'($urandom);
      @(posedge clk); #1;
    end
    bus_wr = 1'b0; bus_rd = 1'b0;
    cyc();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule